// File: doc/BRIEF.md
# Metastable Challenge Search and Corrected Bit Generator

This controller drives the challenge input of an external delay-based physically unclonable function. It looks for a challenge whose response sits on the edge of metastability, and it uses that challenge to produce random bits. The controller holds each challenge steady for a programmable settle time before each response is captured. It gathers responses in fixed-length windows and counts the ones in each window. A window is accepted when that count is close enough to half the window length.

A candidate challenge gets a limited number of windows to qualify. If none of them qualifies, the next candidate comes from a 32-bit maximal-length LFSR. Once a challenge qualifies, the controller enters generation. Captured responses are grouped into pairs and passed through a von Neumann corrector. Temperature and voltage drift can make a qualified challenge stable again, so each block of raw generation samples is tested against the same band. A failing block sends the controller back to searching.

Top module: `puf_chal_search`

## Requirements
- R1: While rst_n is low, searching is 1, challenge equals the SEED parameter and rnd_valid is 0.
- R2: In the search and generate phases, resp_take pulses high for one cycle once every SETTLE+1 cycles, and puf_resp is captured on the clock edge that ends that cycle. The first pulse after reset comes SETTLE+1 cycles after the first active edge. Each evaluation step adds one idle cycle, and each challenge change adds one more.
- R3: A window is WIN_LEN captured responses. It qualifies when its count of ones, n, satisfies |n - WIN_LEN/2| <= band.
- R4: After MAX_WIN consecutive windows fail during search, challenge advances by one LFSR step. At no other time does challenge change.
- R5: The LFSR step maps c to {c[30:0], c[31]^c[21]^c[1]^c[0]}. Starting from a nonzero seed, challenge is never zero.
- R6: searching drops to 0 only after a window qualifies. It stays 0 for as long as generation continues.
- R7: In generation, captured bits are paired in capture order, starting with the first capture after qualification. An equal pair produces no output. An unequal pair produces a one-cycle rnd_valid pulse, with rnd_bit set to the first bit of the pair.
- R8: Every WIN_LEN generation captures are judged with the band of R3. A failing block raises searching again and restarts search on the same challenge with a fresh budget of MAX_WIN windows.
- R9: The band input is programmable. A response stream that fails with one band value qualifies with a wider one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| band | input | $clog2(WIN_LEN/2+1) | Allowed distance of the ones count from WIN_LEN/2 |
| puf_resp | input | 1 | Response bit from the PUF |
| challenge | output | 32 | Challenge applied to the PUF |
| resp_take | output | 1 | puf_resp is captured at the end of this cycle |
| searching | output | 1 | High while no qualified challenge is in use |
| rnd_valid | output | 1 | Corrected output bit is valid |
| rnd_bit | output | 1 | Corrected output bit |

## Verification
The bench models the PUF. The seed challenge gives a stuck response. The next challenge gives six ones per window, which misses a band of one by a single count. The third challenge gives a balanced stream whose first window sits exactly on the band edge, and which later drifts to all ones. A design with an off-by-one in the band test would either accept the near miss or reject the edge window, and the challenge sequence would then diverge from the expected LFSR chain. A design with a wrong window budget shows up as a wrong number of captures between challenge changes. A design that corrects the wrong member of a pair, or that lets search-window bits leak into the corrector, emits bits that do not match the scoreboard. A design that ignores the drift recheck never raises searching again. A second run with a wider band makes the near-miss challenge qualify.

// File: rtl/puf_chal_search.sv
module puf_chal_search #(
  parameter int WIN_LEN = 8,
  parameter int SETTLE = 2,
  parameter int MAX_WIN = 3,
  parameter logic [31:0] SEED = 32'hACE1_5EED,
  localparam int BW = $clog2(WIN_LEN/2 + 1),
  localparam int CNT_W = $clog2(WIN_LEN + 1),
  localparam int SET_W = $clog2(SETTLE + 1),
  localparam int WC_W = $clog2(MAX_WIN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] band,
  input  logic          puf_resp,
  output logic [31:0]   challenge,
  output logic          resp_take,
  output logic          searching,
  output logic          rnd_valid,
  output logic          rnd_bit
);
  typedef enum logic [1:0] {SEARCH, EVALUATE, GENERATE, NEWCHAL} state_t;
  localparam logic [CNT_W-1:0] HALF = CNT_W'(WIN_LEN/2);

  state_t           state;
  logic [SET_W-1:0] set_cnt;
  logic [CNT_W-1:0] samp_cnt, ones, diff;
  logic [WC_W-1:0]  win_cnt;
  logic             gen_mode, have, first;

  assign resp_take = (state == SEARCH || state == GENERATE) && set_cnt == SET_W'(SETTLE);
  assign searching = !(state == GENERATE || (state == EVALUATE && gen_mode));
  assign diff = (ones >= HALF) ? ones - HALF : HALF - ones;
  wire   in_band = diff <= CNT_W'(band);
  wire   last_samp = samp_cnt == CNT_W'(WIN_LEN - 1);
  wire [31:0] lfsr_next = {challenge[30:0], challenge[31] ^ challenge[21] ^ challenge[1] ^ challenge[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SEARCH;
      challenge <= SEED;
      set_cnt <= '0;
      samp_cnt <= '0;
      ones <= '0;
      win_cnt <= '0;
      gen_mode <= 1'b0;
      have <= 1'b0;
      first <= 1'b0;
      rnd_valid <= 1'b0;
      rnd_bit <= 1'b0;
    end else begin
      rnd_valid <= 1'b0;
      case (state)
        SEARCH, GENERATE: begin
          set_cnt <= resp_take ? '0 : set_cnt + SET_W'(1);
          if (resp_take) begin
            ones <= ones + CNT_W'(puf_resp);
            if (state == GENERATE) begin
              if (!have) begin
                first <= puf_resp;
                have <= 1'b1;
              end else begin
                have <= 1'b0;
                rnd_valid <= first != puf_resp;
                rnd_bit <= first;
              end
            end
            if (last_samp) begin
              samp_cnt <= '0;
              gen_mode <= state == GENERATE;
              state <= EVALUATE;
            end else begin
              samp_cnt <= samp_cnt + CNT_W'(1);
            end
          end
        end
        EVALUATE: begin
          ones <= '0;
          have <= 1'b0;
          if (in_band) begin
            state <= GENERATE;
            win_cnt <= '0;
          end else if (gen_mode) begin
            state <= SEARCH;
            win_cnt <= '0;
          end else if (win_cnt == WC_W'(MAX_WIN - 1)) begin
            state <= NEWCHAL;
            win_cnt <= '0;
          end else begin
            state <= SEARCH;
            win_cnt <= win_cnt + WC_W'(1);
          end
        end
        default: begin
          challenge <= lfsr_next;
          state <= SEARCH;
        end
      endcase
    end
  end

  a_r4_chal_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(state == NEWCHAL) |-> $stable(challenge));
  a_r5_chal_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    challenge != 32'd0);
  a_r3_ones_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= CNT_W'(WIN_LEN));
  a_r4_budget: assert property (@(posedge clk) disable iff (!rst_n)
    win_cnt < WC_W'(MAX_WIN));
  a_r7_valid_gen: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_valid |-> !searching);
  a_r6_lock_from_eval: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(searching) |-> $past(state == EVALUATE));
endmodule

// File: tb/puf_chal_search_tb.sv
module puf_chal_search_tb;
  localparam int WIN_LEN = 8, SETTLE = 2, MAX_WIN = 3;
  localparam logic [31:0] SEED = 32'hACE1_5EED;

  logic clk = 1'b0, rst_n = 1'b0, puf_resp;
  logic [1:0] band = 2'd1;
  logic [31:0] challenge;
  logic resp_take, searching, rnd_valid, rnd_bit;

  puf_chal_search #(.WIN_LEN(WIN_LEN), .SETTLE(SETTLE), .MAX_WIN(MAX_WIN), .SEED(SEED)) u_dut (
    .clk(clk), .rst_n(rst_n), .band(band), .puf_resp(puf_resp), .challenge(challenge),
    .resp_take(resp_take), .searching(searching), .rnd_valid(rnd_valid), .rnd_bit(rnd_bit));

  always #4 clk = ~clk;

  function automatic logic [31:0] lnext(input logic [31:0] c);
    return {c[30:0], c[31] ^ c[21] ^ c[1] ^ c[0]};
  endfunction

  localparam logic [31:0] C0 = SEED;
  localparam logic [31:0] C1 = lnext(C0);
  localparam logic [31:0] C2 = lnext(C1);
  localparam logic [31:0] PAT = 32'hC53A_966D;
  localparam logic [7:0] NEAR = 8'b0111_0111;

  int checks = 0, errors = 0, phase = 1, nchanges = 0, takes = 0, cyc = 0, last_take = -1, k = 0;
  bit gen_seen = 0, done = 0;
  bit q[$];
  logic [31:0] prev = SEED, kchal = SEED;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always_comb begin
    if (challenge == C2) puf_resp = (k < 32) ? PAT[k] : 1'b1;
    else if (challenge == C1) puf_resp = NEAR[k % 8];
    else puf_resp = 1'b1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      k <= 0;
      kchal <= SEED;
    end else if (challenge != kchal) begin
      k <= 0;
      kchal <= challenge;
    end else if (resp_take) k <= k + 1;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      prev = SEED; takes = 0; cyc = 0; last_take = -1;
    end else if (!done) begin
      cyc++;
      if (rnd_valid) begin
        if (q.size() == 0) chk(0, "R7", "unexpected output bit", rnd_bit, 0);
        else begin
          automatic bit e = q.pop_front();
          chk(rnd_bit == e, "R7", "corrected bit", rnd_bit, e);
        end
      end
      if (resp_take) begin
        if (last_take < 0) chk(cyc == SETTLE + 1, "R2", "first capture cycle", cyc, SETTLE + 1);
        else chk(cyc - last_take >= SETTLE + 1 && cyc - last_take <= SETTLE + 3, "R2", "capture spacing", cyc - last_take, SETTLE + 1);
        last_take = cyc;
        takes++;
      end
      if (challenge != prev) begin
        automatic int exp_t = (prev == C2) ? 8 * WIN_LEN : MAX_WIN * WIN_LEN;
        chk(challenge == lnext(prev), "R5", "next challenge", challenge, lnext(prev));
        chk(takes == exp_t, (prev == C2) ? "R8" : "R4", "captures before change", takes, exp_t);
        prev = challenge; takes = 0; nchanges++;
      end
      if (!searching) begin
        gen_seen = 1;
        chk(challenge == ((phase == 1) ? C2 : C1), (phase == 1) ? "R6" : "R9", "locked challenge", challenge, (phase == 1) ? C2 : C1);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual %0d expected %0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 8; i < 40; i += 2) begin
      automatic bit a = (i < 32) ? PAT[i] : 1'b1;
      automatic bit b = (i + 1 < 32) ? PAT[i + 1] : 1'b1;
      if (a != b) q.push_back(a);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(searching == 1'b1, "R1", "searching in reset", searching, 1);
    chk(challenge == SEED, "R1", "challenge in reset", challenge, SEED);
    chk(rnd_valid == 1'b0, "R1", "valid in reset", rnd_valid, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    wait (nchanges == 3);
    @(negedge clk);
    chk(gen_seen == 1'b1, "R6", "generation reached", gen_seen, 1);
    chk(searching == 1'b1, "R8", "searching after drift", searching, 1);
    chk(q.size() == 0, "R7", "outputs left over", q.size(), 0);
    rst_n = 1'b0; band = 2'd2; phase = 2; gen_seen = 0; nchanges = 0;
    q.delete();
    for (int w = 0; w < 4; w++)
      for (int j = 0; j < 8; j += 2)
        if (NEAR[j] != NEAR[j + 1]) q.push_back(NEAR[j]);
    repeat (3) @(posedge clk);
    @(posedge clk); #1 rst_n = 1'b1;
    wait (q.size() == 0);
    @(negedge clk);
    done = 1;
    chk(gen_seen == 1'b1, "R9", "wider band qualifies", gen_seen, 1);
    chk(nchanges == 1, "R9", "challenge changes", nchanges, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule